// File: doc/BRIEF.md
# Predicated Condition-Flag Register Update

This block keeps the condition-code state of a micro-coded core as five separate small registers. The first is a four-bit group of parity, half-carry, zero and sign. The second is a two-bit group of carry and overflow. The last three are one bit each: direction, an emulation carry and an emulation zero.

Each executing micro-op presents a nine-bit select mask and nine freshly computed flag values. For every group the block decides two things from the mask alone. It decides whether the old contents must be read, which is needed only when some bits of the group change and others are kept. It also decides whether the group is written at all. The selected bits are merged over the kept bits, and the result is shown in the same cycle. Saturating counters record, per group, how many operations skipped the read and how many skipped the write.

The same predicate decode is also offered on a separate plan port that is not gated by the operation valid. An issue stage can use it when the micro-op is set up, to learn which register ports the op will need. At execution the predicates are evaluated again, this time gating the actual read and write strobes.

Bit layout of the select mask, the new values and the state, with bit 0 first: parity, half-carry, zero, sign, carry, overflow, direction, emulation carry, emulation zero. Group index 0 is parity/half-carry/zero/sign (bits 3:0). Group 1 is carry/overflow (bits 5:4). Group 2 is direction (bit 6), group 3 is emulation carry (bit 7) and group 4 is emulation zero (bit 8).

Top module: `flag_pred_regs`

## Requirements
- R1: Group 0 is read only when one, two or three of mask bits 3:0 are set; with none or all four set, its read strobe stays low.
- R2: Group 0 is written whenever at least one of mask bits 3:0 is set.
- R3: Group 1 is read only when exactly one of mask bits 4 and 5 is set.
- R4: Group 1 is written whenever mask bit 4 or bit 5 is set.
- R5: Groups 2, 3 and 4 are never read; each is written only when its own mask bit (6, 7 or 8) is set.
- R6: plan_rd/plan_wr decode plan_sel by the rules of R1 to R5 with no dependence on op_valid; rd_stb/wr_stb use the same rules on op_sel, and only while op_valid is high.
- R7: After a valid operation, every selected state bit holds the new value and every unselected bit keeps its prior value; a group whose read was elided takes its new bits with no effect from stale contents.
- R8: merged_o shows, in the cycle of a valid operation, the value state_o takes after the next clock edge; this forwards the write to a same-cycle reader. Without op_valid, merged_o equals state_o and the state does not change.
- R9: Each group has a CNT_W-bit counter that rises by one for every valid operation that elides that group's read, and another that rises for every valid operation that elides its write; both hold at all ones instead of wrapping.
- R10: A synchronous reset clears the state and all counters to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| plan_sel | input | 9 | Select mask of a micro-op being set up |
| plan_rd | output | 5 | Groups the planned op will need to read |
| plan_wr | output | 5 | Groups the planned op will write |
| op_valid | input | 1 | An operation executes this cycle |
| op_sel | input | 9 | Select mask of the executing operation |
| op_new | input | 9 | Newly computed flag values |
| rd_stb | output | 5 | Per-group read strobes of the executing operation |
| wr_stb | output | 5 | Per-group write strobes of the executing operation |
| state_o | output | 9 | Registered flag state |
| merged_o | output | 9 | Post-operation flag value, forwarded |
| rd_skip_cnt | output | 5 x CNT_W | Per-group elided-read counts |
| wr_skip_cnt | output | 5 x CNT_W | Per-group elided-write counts |

## Verification
Every one of the 512 select masks is applied with three new-value patterns: all ones, all zeros and a mixed pattern. The ones and zeros patterns show whether unselected bits truly keep their prior value, since those bits alternate between values across the sweep. The mixed pattern catches bits routed to the wrong position. The plan port is driven with the inverted mask at the same time, which separates the plan decode from the execution decode. An idle window confirms that state and counters do not move, and a long run of empty masks drives every counter into saturation before a final reset.

// File: rtl/flag_pred_regs.sv
module flag_pred_regs #(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [8:0]            plan_sel,
  output logic [4:0]            plan_rd,
  output logic [4:0]            plan_wr,
  input  logic                  op_valid,
  input  logic [8:0]            op_sel,
  input  logic [8:0]            op_new,
  output logic [4:0]            rd_stb,
  output logic [4:0]            wr_stb,
  output logic [8:0]            state_o,
  output logic [8:0]            merged_o,
  output logic [4:0][CNT_W-1:0] rd_skip_cnt,
  output logic [4:0][CNT_W-1:0] wr_skip_cnt
);
  localparam int NGRP = 5;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [NGRP-1:0][8:0] GMASK = {9'h100, 9'h080, 9'h040, 9'h030, 9'h00F};

  function automatic logic [4:0] need_rd(input logic [8:0] s);
    need_rd = 5'b0;
    need_rd[0] = (s[3:0] != 4'h0) && (s[3:0] != 4'hF);
    need_rd[1] = s[4] ^ s[5];
  endfunction

  function automatic logic [4:0] need_wr(input logic [8:0] s);
    need_wr = {s[8], s[7], s[6], |s[5:4], |s[3:0]};
  endfunction

  logic [8:0] state_q;

  assign plan_rd = need_rd(plan_sel);
  assign plan_wr = need_wr(plan_sel);
  assign rd_stb  = op_valid ? need_rd(op_sel) : 5'b0;
  assign wr_stb  = op_valid ? need_wr(op_sel) : 5'b0;
  assign state_o = state_q;

  always_comb begin
    merged_o = state_q;
    for (int g = 0; g < NGRP; g++) begin
      if (wr_stb[g])
        merged_o = (merged_o & ~GMASK[g]) |
                   ((((rd_stb[g] ? state_q : 9'h0) & ~op_sel) | (op_new & op_sel)) & GMASK[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= 9'h0;
    else     state_q <= merged_o;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_skip_cnt[g] <= '0;
        wr_skip_cnt[g] <= '0;
      end else begin
        if (op_valid && !rd_stb[g] && rd_skip_cnt[g] != CNT_MAX)
          rd_skip_cnt[g] <= rd_skip_cnt[g] + 1'b1;
        if (op_valid && !wr_stb[g] && wr_skip_cnt[g] != CNT_MAX)
          wr_skip_cnt[g] <= wr_skip_cnt[g] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flag_pred_regs_chk.sv
module flag_pred_regs_chk #(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic [8:0]            plan_sel,
  input logic [4:0]            plan_rd,
  input logic [4:0]            plan_wr,
  input logic                  op_valid,
  input logic [8:0]            op_sel,
  input logic [8:0]            op_new,
  input logic [4:0]            rd_stb,
  input logic [4:0]            wr_stb,
  input logic [8:0]            state_o,
  input logic [8:0]            merged_o,
  input logic [4:0][CNT_W-1:0] rd_skip_cnt,
  input logic [4:0][CNT_W-1:0] wr_skip_cnt
);
  assert_rd_partial_R1: assert property (@(posedge clk) disable iff (rst)
    rd_stb[0] |-> (op_sel[3:0] != 4'h0 && op_sel[3:0] != 4'hF));

  assert_wr_any_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel[3:0] != 4'h0) |-> wr_stb[0]);

  assert_rd_single_R3: assert property (@(posedge clk) disable iff (rst)
    rd_stb[1] |-> $countones(op_sel[5:4]) == 1);

  assert_wr_pair_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel[5:4] != 2'b00) |-> wr_stb[1]);

  assert_single_wr_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_stb[4:2] & ~op_sel[8:6]) == 3'b000);

  assert_strobe_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> (rd_stb == 5'b0 && wr_stb == 5'b0));

  assert_rd_has_wr_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb & ~wr_stb) == 5'b0);

  assert_unsel_hold_R7: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (state_o & ~$past(op_sel)) == ($past(state_o) & ~$past(op_sel)));

  assert_sel_take_R7: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (state_o & $past(op_sel)) == ($past(op_new) & $past(op_sel)));

  assert_fwd_R8: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> state_o == $past(merged_o));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(state_o));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_skip_cnt[2] == {CNT_W{1'b1}}) |=> (rd_skip_cnt[2] == {CNT_W{1'b1}}));
endmodule

bind flag_pred_regs flag_pred_regs_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/flag_pred_regs_tb_top.sv
`timescale 1ns/1ps
module flag_pred_regs_tb_top;
  localparam int CW = 16;
  localparam int CMAX = 65535;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] plan_sel = '0;
  logic [4:0] plan_rd, plan_wr;
  logic op_valid = 1'b0;
  logic [8:0] op_sel = '0;
  logic [8:0] op_new = '0;
  logic [4:0] rd_stb, wr_stb;
  logic [8:0] state_o, merged_o;
  logic [4:0][CW-1:0] rd_skip_cnt, wr_skip_cnt;

  int checks = 0;
  int failures = 0;
  logic [8:0] exp_state = '0;
  int mrd [5];
  int mwr [5];

  always #2.5 clk = ~clk;

  flag_pred_regs #(.CNT_W(CW)) dut_i (.*);

  function automatic logic [4:0] m_rd(input logic [8:0] s);
    int n;
    n = $countones(s[3:0]);
    m_rd = 5'b0;
    m_rd[0] = (n >= 1 && n <= 3);
    m_rd[1] = ($countones(s[5:4]) == 1);
  endfunction

  function automatic logic [4:0] m_wr(input logic [8:0] s);
    m_wr = 5'b0;
    m_wr[0] = ($countones(s[3:0]) > 0);
    m_wr[1] = ($countones(s[5:4]) > 0);
    m_wr[2] = s[6];
    m_wr[3] = s[7];
    m_wr[4] = s[8];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_cnts(input string tag);
    for (int g = 0; g < 5; g++) begin
      chk({"R9 rd count ", tag}, 32'(rd_skip_cnt[g]), 32'(mrd[g]));
      chk({"R9 wr count ", tag}, 32'(wr_skip_cnt[g]), 32'(mwr[g]));
    end
  endtask

  task automatic do_op(input logic [8:0] s, input logic [8:0] nv);
    logic [4:0] er, ew;
    er = m_rd(s);
    ew = m_wr(s);
    op_valid = 1'b1;
    op_sel = s;
    op_new = nv;
    plan_sel = ~s;
    #1;
    chk("R1 R3 R5 rd_stb", 32'(rd_stb), 32'(er));
    chk("R2 R4 R5 wr_stb", 32'(wr_stb), 32'(ew));
    chk("R6 plan_rd", 32'(plan_rd), 32'(m_rd(~s)));
    chk("R6 plan_wr", 32'(plan_wr), 32'(m_wr(~s)));
    exp_state = (exp_state & ~s) | (nv & s);
    chk("R8 merged_o", 32'(merged_o), 32'(exp_state));
    for (int g = 0; g < 5; g++) begin
      if (!er[g] && mrd[g] < CMAX) mrd[g]++;
      if (!ew[g] && mwr[g] < CMAX) mwr[g]++;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R7 state_o", 32'(state_o), 32'(exp_state));
  endtask

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int g = 0; g < 5; g++) begin mrd[g] = 0; mwr[g] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 reset state", 32'(state_o), 32'h0);
    chk_cnts("R10 after reset");

    for (int s = 0; s < 512; s++)
      for (int p = 0; p < 3; p++) begin
        logic [8:0] nv;
        nv = (p == 0) ? 9'h1FF : (p == 1) ? 9'h000 : (9'(s * 37 + p * 91) ^ 9'h15A);
        do_op(9'(s), nv);
      end
    chk_cnts("after sweep");

    op_valid = 1'b0;
    op_sel = 9'h1FF;
    op_new = ~exp_state;
    plan_sel = 9'h00C;
    #1;
    chk("R6 idle rd_stb", 32'(rd_stb), 32'h0);
    chk("R6 idle wr_stb", 32'(wr_stb), 32'h0);
    chk("R6 plan_rd idle", 32'(plan_rd), 32'(m_rd(9'h00C)));
    chk("R8 idle merged", 32'(merged_o), 32'(exp_state));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8 idle state", 32'(state_o), 32'(exp_state));
    chk_cnts("R9 idle");

    op_valid = 1'b1;
    op_sel = 9'h000;
    repeat (65600) @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    for (int g = 0; g < 5; g++) begin mrd[g] = CMAX; mwr[g] = CMAX; end
    chk_cnts("saturated");
    chk("R7 empty mask state", 32'(state_o), 32'(exp_state));
    do_op(9'h00F, 9'h005);
    chk_cnts("no wrap");

    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_state = '0;
    for (int g = 0; g < 5; g++) begin mrd[g] = 0; mwr[g] = 0; end
    #1;
    chk("R10 second reset state", 32'(state_o), 32'h0);
    chk_cnts("R10 second reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule